// File: doc/BRIEF.md
# Scanned Six-Digit Display Driver with Field Blink

This block drives six multiplexed seven-segment digits. A small scan counter steps through the digit positions. At each position it enables exactly one digit line and puts the segment pattern for that digit's 4-bit code on a shared segment bus. A select input picks the source of all six digits: the running time of day, or the stored alarm time. Both sources arrive as packed BCD buses holding hours, minutes and seconds, two digits each.

A mode controller can mark any of the three fields (hours, minutes, seconds) as under adjustment. While a field's flag is set and the slow blink clock is high, both digits of that field show the blank code, so the field flashes. The scan counter advances only on a scan tick strobe, supplied from outside at roughly 1 kHz. A parameter sets the counter's range. It can wrap after the sixth position, or it can run through all eight codes of its 3-bit range. In the second case the two spare positions enable no digit and drive the separator pattern, which lights only the middle bar.

Top module: `seg_scan_display`

## Requirements
- R1: While rst_n is low, scan_pos is 0, digit_en is 6'b000001 and seg shows the position-0 digit.
- R2: scan_pos increases by one at each rising clock edge where scan_tick is high. It holds its value at every edge where scan_tick is low.
- R3: With SKIP_UNUSED=1, scan_pos wraps from 5 to 0. With SKIP_UNUSED=0, it counts through 6 and 7 and wraps from 7 to 0.
- R4: For scan_pos p in 0..5, digit_en has only bit p set. For scan_pos 6 or 7, digit_en is all zero.
- R5: Position p shows the nibble at bits [(5-p)*4+3:(5-p)*4] of the selected bus. Position 0 is the hours tens digit and position 5 is the seconds units digit.
- R6: show_alarm=1 selects alarm_digits and show_alarm=0 selects time_digits. The bus not selected has no effect on seg.
- R7: When blink=1 and a field's flag is set, both digits of that field show the blank code. The hours field (flag flash_hr) is positions 0–1, minutes (flash_min) is 2–3 and seconds (flash_sec) is 4–5. When blink=0, or the flag is clear, the digit shows its bus value.
- R8: seg is {a,b,c,d,e,f,g}, active high, with a on bit 6. Codes 0..9 give 7E,30,6D,79,33,5B,5F,70,7F,7B (hex).
- R9: The blank code 4'b1111 gives seg = 7'h00.
- R10: Codes 4'b1010 through 4'b1110 give seg = 7'h01, which lights only segment g.
- R11: With SKIP_UNUSED=0, scan positions 6 and 7 show the separator code 4'b1010, so seg = 7'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | One-cycle strobe that advances the scan position |
| show_alarm | input | 1 | 1 selects the alarm digits, 0 selects the time digits |
| blink | input | 1 | Slow blink clock; flagged fields blank while it is high |
| flash_hr | input | 1 | Hours field under adjustment |
| flash_min | input | 1 | Minutes field under adjustment |
| flash_sec | input | 1 | Seconds field under adjustment |
| time_digits | input | 24 | Time of day, packed BCD, hours tens in the top nibble |
| alarm_digits | input | 24 | Alarm time, packed BCD, same layout |
| digit_en | output | 6 | One-hot digit enable, bit p for scan position p |
| seg | output | 7 | Segment pattern {a,b,c,d,e,f,g}, active high |
| scan_pos | output | 3 | Current scan position |

## Verification
A corrupted scan position shows up within one tick. It appears as a digit enable that does not match the expected step, or as a digit from the wrong bus nibble. Either one corrupts a whole pass of the display. Errors in selection, blink substitution or decoding are combinational and visible on seg in the same cycle as the input change. For that reason, every position is swept against every code, both sources, all flag combinations and both blink phases. The spare positions and both wrap points are reached in the full-range variant.

// File: rtl/clkdisp_pkg.sv
package clkdisp_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    localparam logic [DIGIT_W-1:0] CODE_BLANK = 4'b1111;
    localparam logic [DIGIT_W-1:0] CODE_SEP   = 4'b1010;

    // Segment order {a,b,c,d,e,f,g}, active high
    function automatic logic [SEG_W-1:0] seg_pattern(input logic [DIGIT_W-1:0] code);
        logic [SEG_W-1:0] pat;
        case (code)
            4'd0:       pat = 7'b1111110;
            4'd1:       pat = 7'b0110000;
            4'd2:       pat = 7'b1101101;
            4'd3:       pat = 7'b1111001;
            4'd4:       pat = 7'b0110011;
            4'd5:       pat = 7'b1011011;
            4'd6:       pat = 7'b1011111;
            4'd7:       pat = 7'b1110000;
            4'd8:       pat = 7'b1111111;
            4'd9:       pat = 7'b1111011;
            CODE_BLANK: pat = 7'b0000000;
            default:    pat = 7'b0000001;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int POS_W = 3,
    parameter int LAST  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [POS_W-1:0] pos
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } scan_state_t;

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(LAST);

    scan_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (tick) begin
            if (state_q.pos == LAST_POS) begin
                state_d.pos = '0;
            end else begin
                state_d.pos = state_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pos = state_q.pos;

endmodule

// File: rtl/pos_decoder.sv
module pos_decoder #(
    parameter int POS_W      = 3,
    parameter int NUM_DIGITS = 6
) (
    input  logic [POS_W-1:0]      pos,
    output logic [NUM_DIGITS-1:0] en
);

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_line
        assign en[i] = (pos == POS_W'(i));
    end

endmodule

// File: rtl/digit_picker.sv
module digit_picker
    import clkdisp_pkg::*;
#(
    parameter int POS_W      = 3,
    parameter int NUM_DIGITS = 6
) (
    input  logic [POS_W-1:0]              pos,
    input  logic                          show_alarm,
    input  logic                          blink,
    input  logic [NUM_DIGITS/2-1:0]       flash,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] time_digits,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] alarm_digits,
    output logic [DIGIT_W-1:0]            code
);

    logic [NUM_DIGITS*DIGIT_W-1:0] src;
    logic [DIGIT_W-1:0]            raw;
    logic                          hide;
    logic                          in_range;

    assign src = show_alarm ? alarm_digits : time_digits;

    always_comb begin
        raw      = CODE_SEP;
        hide     = 1'b0;
        in_range = 1'b0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (pos == POS_W'(i)) begin
                raw      = src[(NUM_DIGITS-1-i)*DIGIT_W +: DIGIT_W];
                hide     = flash[i/2] & blink;
                in_range = 1'b1;
            end
        end
        if (!in_range) begin
            code = CODE_SEP;
        end else if (hide) begin
            code = CODE_BLANK;
        end else begin
            code = raw;
        end
    end

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import clkdisp_pkg::*;
(
    input  logic [DIGIT_W-1:0] code,
    output logic [SEG_W-1:0]   seg
);

    assign seg = seg_pattern(code);

endmodule

// File: rtl/seg_scan_display.sv
module seg_scan_display
    import clkdisp_pkg::*;
#(
    parameter int NUM_DIGITS  = 6,
    parameter bit SKIP_UNUSED = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scan_tick,
    input  logic                          show_alarm,
    input  logic                          blink,
    input  logic                          flash_hr,
    input  logic                          flash_min,
    input  logic                          flash_sec,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] time_digits,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] alarm_digits,
    output logic [NUM_DIGITS-1:0]         digit_en,
    output logic [SEG_W-1:0]              seg,
    output logic [$clog2(NUM_DIGITS)-1:0] scan_pos
);

    localparam int POS_W  = $clog2(NUM_DIGITS);
    localparam int FIELDS = NUM_DIGITS / 2;
    localparam int LAST   = SKIP_UNUSED ? NUM_DIGITS - 1 : (1 << POS_W) - 1;

    logic [FIELDS-1:0]  flash;
    logic [DIGIT_W-1:0] code;

    // field 0 = hours (leftmost), field 2 = seconds
    assign flash = {flash_sec, flash_min, flash_hr};

    scan_counter #(.POS_W(POS_W), .LAST(LAST)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (scan_tick),
        .pos   (scan_pos)
    );

    pos_decoder #(.POS_W(POS_W), .NUM_DIGITS(NUM_DIGITS)) u_dec (
        .pos (scan_pos),
        .en  (digit_en)
    );

    digit_picker #(.POS_W(POS_W), .NUM_DIGITS(NUM_DIGITS)) u_pick (
        .pos          (scan_pos),
        .show_alarm   (show_alarm),
        .blink        (blink),
        .flash        (flash),
        .time_digits  (time_digits),
        .alarm_digits (alarm_digits),
        .code         (code)
    );

    seg_decoder u_seg (
        .code (code),
        .seg  (seg)
    );

endmodule

// File: rtl/seg_scan_display_chk.sv
module seg_scan_display_chk #(
    parameter int NUM_DIGITS  = 6,
    parameter bit SKIP_UNUSED = 1'b1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          scan_tick,
    input logic                          blink,
    input logic                          flash_hr,
    input logic                          flash_min,
    input logic                          flash_sec,
    input logic [NUM_DIGITS-1:0]         digit_en,
    input logic [6:0]                    seg,
    input logic [$clog2(NUM_DIGITS)-1:0] scan_pos
);

    localparam int POS_W = $clog2(NUM_DIGITS);
    localparam int LAST  = SKIP_UNUSED ? NUM_DIGITS - 1 : (1 << POS_W) - 1;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(LAST);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(scan_pos));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && scan_pos != LAST_POS) |=> scan_pos == POS_W'($past(scan_pos) + 1'b1));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && scan_pos == LAST_POS) |=> scan_pos == '0);

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_pos <= LAST_POS);

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_en));

    p_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_pos < POS_W'(NUM_DIGITS)) |-> $countones(digit_en) == 1);

    p_blank_hr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_hr && blink && (digit_en[0] || digit_en[1])) |-> seg == 7'h00);

    p_blank_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_min && blink && (digit_en[2] || digit_en[3])) |-> seg == 7'h00);

    p_blank_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_sec && blink && (digit_en[4] || digit_en[5])) |-> seg == 7'h00);

    p_spare_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_en == '0) |-> seg == 7'h01);

endmodule

bind seg_scan_display seg_scan_display_chk #(
    .NUM_DIGITS  (NUM_DIGITS),
    .SKIP_UNUSED (SKIP_UNUSED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .blink     (blink),
    .flash_hr  (flash_hr),
    .flash_min (flash_min),
    .flash_sec (flash_sec),
    .digit_en  (digit_en),
    .seg       (seg),
    .scan_pos  (scan_pos)
);

// File: tb/seg_scan_display_bench.sv
module seg_scan_display_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scan_tick;
    logic        show_alarm;
    logic        blink;
    logic        flash_hr, flash_min, flash_sec;
    logic [23:0] time_digits, alarm_digits;
    logic [5:0]  en_a, en_b;
    logic [6:0]  seg_a, seg_b;
    logic [2:0]  pos_a, pos_b;

    int checks = 0;
    int errors = 0;
    int exp_a  = 0;
    int exp_b  = 0;

    always #2 clk = ~clk;

    seg_scan_display u_seg_scan_display (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .show_alarm(show_alarm),
        .blink(blink), .flash_hr(flash_hr), .flash_min(flash_min), .flash_sec(flash_sec),
        .time_digits(time_digits), .alarm_digits(alarm_digits),
        .digit_en(en_a), .seg(seg_a), .scan_pos(pos_a)
    );

    seg_scan_display #(.SKIP_UNUSED(1'b0)) u_seg_scan_display_full (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .show_alarm(show_alarm),
        .blink(blink), .flash_hr(flash_hr), .flash_min(flash_min), .flash_sec(flash_sec),
        .time_digits(time_digits), .alarm_digits(alarm_digits),
        .digit_en(en_b), .seg(seg_b), .scan_pos(pos_b)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] c);
        case (c)
            4'd0: return 7'h7E;  4'd1: return 7'h30;  4'd2: return 7'h6D;
            4'd3: return 7'h79;  4'd4: return 7'h33;  4'd5: return 7'h5B;
            4'd6: return 7'h5F;  4'd7: return 7'h70;  4'd8: return 7'h7F;
            4'd9: return 7'h7B;  4'd15: return 7'h00;
            default: return 7'h01;
        endcase
    endfunction

    function automatic logic [5:0] ref_en(input int p);
        return (p < 6) ? 6'(1 << p) : 6'b0;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) scan_tick = 1'b0;
        #1;
        exp_a = (exp_a == 5) ? 0 : exp_a + 1;
        exp_b = (exp_b == 7) ? 0 : exp_b + 1;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scan_tick = 1'b0; show_alarm = 1'b0; blink = 1'b0;
        flash_hr = 1'b0; flash_min = 1'b0; flash_sec = 1'b0;
        time_digits = 24'h234567; alarm_digits = 24'h888888;
        repeat (3) @(negedge clk);
        #1;
        check("R1 pos", int'(pos_a), 0);
        check("R1 en", int'(en_a), 1);
        check("R1 seg", int'(seg_a), int'(ref_seg(4'd2)));
        check("R1 full pos", int'(pos_b), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        check("R2 hold", int'(pos_a), 0);
        check("R2 hold full", int'(pos_b), 0);

        for (int p = 0; p < 6; p++) begin
            check("R2 pos", int'(pos_a), exp_a);
            check("R2 pos full", int'(pos_b), exp_b);
            check("R4 en", int'(en_a), int'(ref_en(exp_a)));
            check("R4 en full", int'(en_b), int'(ref_en(exp_b)));
            for (int c = 0; c < 16; c++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int f = 0; f < 8; f++) begin
                        for (int b = 0; b < 2; b++) begin
                            logic [3:0] cv;
                            logic [3:0] shown;
                            cv = 4'(c);
                            time_digits  = 24'h888888;
                            alarm_digits = 24'h888888;
                            if (s == 1) begin
                                alarm_digits[(5-p)*4 +: 4] = cv;
                                time_digits[(5-p)*4 +: 4]  = cv ^ 4'h5;
                            end else begin
                                time_digits[(5-p)*4 +: 4]  = cv;
                                alarm_digits[(5-p)*4 +: 4] = cv ^ 4'h5;
                            end
                            show_alarm = s[0];
                            flash_hr = f[0]; flash_min = f[1]; flash_sec = f[2];
                            blink = b[0];
                            #1;
                            shown = (b == 1 && f[p/2] == 1'b1) ? 4'hF : cv;
                            if (shown == 4'hF && cv != 4'hF)
                                check("R7 blank", int'(seg_a), int'(ref_seg(shown)));
                            else if (cv < 10)
                                check("R8 R5 R6 digit", int'(seg_a), int'(ref_seg(shown)));
                            else if (cv == 4'hF)
                                check("R9 blank code", int'(seg_a), 0);
                            else
                                check("R10 other code", int'(seg_a), 1);
                            check("R6 full", int'(seg_b), int'(ref_seg(shown)));
                        end
                    end
                end
            end
            step();
        end
        check("R3 wrap", int'(pos_a), 0);
        check("R3 full passes 5", int'(pos_b), 6);

        time_digits = 24'h000000; alarm_digits = 24'h111111;
        flash_hr = 1'b1; flash_min = 1'b1; flash_sec = 1'b1; blink = 1'b1;
        for (int q = 6; q < 8; q++) begin
            check("R4 spare en", int'(en_b), 0);
            check("R11 separator", int'(seg_b), 1);
            step();
        end
        check("R3 full wrap", int'(pos_b), 0);
        check("R3 default pos", int'(pos_a), exp_a);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule